// File: doc/BRIEF.md
# Machine CSR File with Retirement Trace

This block keeps the machine-level control and status registers of a small RISC-V core. It holds the status word, the exception return address, the counter-enable mask for user mode, a free-running cycle counter and a retired-instruction counter. The pipeline reaches it through a single-cycle access port. The port takes a valid strobe, a 12-bit CSR address, a write enable and write data, and it returns read data and an illegal-access flag in the same cycle. A write takes effect at the clock edge that ends the access.

The block also has a retirement trace port for formal or co-simulation checkers. In every cycle where `ret_valid` is high, the block records two copies of each CSR: the value before the retiring instruction and the value after it. It presents these one cycle later, qualified by `tr_valid`. The trace reports stored architectural state, not the software view. Bit 1 of the return address is never masked on the trace. Both counters appear as full 64-bit values even in a 32-bit build. The status word keeps its 64-bit layout, including the user and supervisor width fields.

There is no control state machine. Each cycle is either idle, a read access, a write access, or one of these combined with a retirement. A small decoder turns the address into a register select: none, status, counter-enable, return address, cycle low, cycle high, retired low or retired high. That select drives both the read multiplexer and the write strobes. A counter changes only at clock edges, never in the middle of a retiring instruction. So the before and after values of a counter differ only when the instruction writes that counter.

Top module: `mcsr_trace_unit`

## Requirements
- R1: After reset, the return address, counter-enable mask and both counters are zero, and the status word reads 0x1800 (previous-privilege field, bits 12:11, set to 11).
- R2: An access-port read of the return address (0x341) returns bit 1 as zero while `c_align_en` is low, and the stored bit 1 while it is high. A write always stores bit 1. Bit 0 always stores zero.
- R3: The trace reports the return address with bit 1 exactly as stored, whatever the state of `c_align_en`.
- R4: The trace reports each counter as one 64-bit value. In a 32-bit build, the low halves are at 0xB00 (cycle) and 0xB02 (retired), and the high halves are at 0xB80 and 0xB82. A carry out of the low half reaches the high half.
- R5: The cycle counter advances by one on every clock edge in which it is not written.
- R6: The retired counter advances by one after each retirement that does not write it, and holds otherwise.
- R7: For a retirement that does not write a given counter, the trace before-value and after-value of that counter are equal.
- R8: A write to either half of a counter replaces that edge's increment. The trace after-value shows the written value, and the next read returns it unchanged.
- R9: Only bit 0 (cycle) and bit 2 (retired) of the counter-enable mask (0x306) are stored. All other bits read zero.
- R10: In the status word (0x300), only bit 3 (interrupt enable), bit 7 (previous interrupt enable) and bits 12:11 (previous privilege) are writable, and all other bits read zero. On the trace the word keeps its 64-bit layout, with bits 33:32 reading 01 when user mode exists in a 32-bit build.
- R11: An access to any address outside the implemented set (0x300, 0x306 when user mode exists, 0x341, 0xB00, 0xB02, and in a 32-bit build 0xB80 and 0xB82) raises `acc_illegal` and changes no register.
- R12: `tr_valid` is high for exactly the cycle after a cycle with `ret_valid` high. During that cycle the trace carries the before and after values of the status word, return address and counter-enable mask for the retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_align_en | input | 1 | High when 16-bit instruction alignment is enabled |
| acc_valid | input | 1 | Access strobe |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | 12 | CSR address |
| acc_wdata | input | XLEN | Write data |
| acc_rdata | output | XLEN | Read data as seen by software |
| acc_illegal | output | 1 | Access targets an unimplemented CSR |
| ret_valid | input | 1 | An instruction retires this cycle |
| tr_valid | output | 1 | Trace fields are valid |
| tr_mstatus_rdata | output | 64 | Status word before the retirement |
| tr_mstatus_wdata | output | 64 | Status word after the retirement |
| tr_mepc_rdata | output | 64 | Return address before, unmasked |
| tr_mepc_wdata | output | 64 | Return address after, unmasked |
| tr_mcounteren_rdata | output | 32 | Counter-enable mask before |
| tr_mcounteren_wdata | output | 32 | Counter-enable mask after |
| tr_mcycle_rdata | output | 64 | Cycle counter before |
| tr_mcycle_wdata | output | 64 | Cycle counter after |
| tr_minstret_rdata | output | 64 | Retired counter before |
| tr_minstret_wdata | output | 64 | Retired counter after |

## Verification
The bench reads all 4096 addresses and then writes every unimplemented one. A decoder with a missing or extra address would flag the wrong set or corrupt a register. It walks the return-address low bits under both alignment settings while a retirement is in flight. A design that masked the stored bit, or that masked the trace, would show bit 1 cleared where it should be set.

Carry from the low half of the cycle counter into the high half is covered by loading 0x5_FFFFFFFE and retiring two edges later. A 32-bit-only counter would report the high half as 5 rather than 6. The bench also puts counter writes on retiring instructions. A design that added the increment on top of the written value would return 0x41 or 0x101 instead of the written value, and one that advanced a counter mid-instruction would report unequal before and after values.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    // Architectural CSR addresses; the decoder keys on these values.
    localparam logic [11:0] A_MSTATUS    = 12'h300;
    localparam logic [11:0] A_MCOUNTEREN = 12'h306;
    localparam logic [11:0] A_MEPC       = 12'h341;
    localparam logic [11:0] A_MCYCLE     = 12'hB00;
    localparam logic [11:0] A_MINSTRET   = 12'hB02;
    localparam logic [11:0] A_MCYCLEH    = 12'hB80;
    localparam logic [11:0] A_MINSTRETH  = 12'hB82;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MSTATUS,
        SEL_MCOUNTEREN,
        SEL_MEPC,
        SEL_CYC_LO,
        SEL_CYC_HI,
        SEL_RET_LO,
        SEL_RET_HI
    } csr_sel_e;

    // Writable status fields: interrupt enable, previous enable, previous privilege.
    localparam logic [63:0] MSTATUS_WMASK = 64'h0000_0000_0000_1888;
    localparam logic [63:0] MSTATUS_RST   = 64'h0000_0000_0000_1800;
    // Counter-enable: cycle bit 0, retired bit 2.
    localparam logic [31:0] MCOUNTEREN_MASK = 32'h0000_0005;

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
    import mcsr_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int HAS_UMODE = 1
) (
    input  logic [11:0] addr,
    output csr_sel_e    sel
);

    localparam bit SPLIT_CNT = (XLEN == 32);
    localparam bit UMODE_ON  = (HAS_UMODE != 0);

    always_comb begin
        unique case (addr)
            A_MSTATUS:    sel = SEL_MSTATUS;
            A_MCOUNTEREN: sel = UMODE_ON ? SEL_MCOUNTEREN : SEL_NONE;
            A_MEPC:       sel = SEL_MEPC;
            A_MCYCLE:     sel = SEL_CYC_LO;
            A_MINSTRET:   sel = SEL_RET_LO;
            A_MCYCLEH:    sel = SPLIT_CNT ? SEL_CYC_HI : SEL_NONE;
            A_MINSTRETH:  sel = SPLIT_CNT ? SEL_RET_HI : SEL_NONE;
            default:      sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [XLEN-1:0] wdata,
    output logic [63:0]     cnt_q,
    output logic [63:0]     cnt_wr
);

    logic [63:0] cnt_d;

    // Value after the instruction's own write, before any increment.
    always_comb begin
        cnt_wr = cnt_q;
        if (wr_lo) cnt_wr[XLEN-1:0] = wdata;
        if (wr_hi) cnt_wr[63:32]    = wdata[31:0];
    end

    always_comb begin
        if (wr_lo || wr_hi) cnt_d = cnt_wr;
        else                cnt_d = cnt_q + 64'(inc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5 / R6: one step per enabled edge when not written
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_lo || wr_hi)) |-> (cnt_q == $past(cnt_q) + 64'($past(inc))));

    // R8: a write replaces the increment
    p_write_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_lo)) |-> (cnt_q[XLEN-1:0] == $past(wdata)));

endmodule

// File: rtl/mcsr_regs.sv
module mcsr_regs
    import mcsr_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          HAS_UMODE = 1,
    parameter logic [1:0]  UXL_VAL   = 2'b01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_mstatus,
    input  logic            wr_mcounteren,
    input  logic            wr_mepc,
    input  logic [XLEN-1:0] wdata,
    output logic [63:0]     mstatus_q,
    output logic [63:0]     mstatus_nxt,
    output logic [XLEN-1:0] mepc_q,
    output logic [XLEN-1:0] mepc_nxt,
    output logic [31:0]     menc_q,
    output logic [31:0]     menc_nxt
);

    localparam logic [63:0] FIXED_BITS  = 64'(UXL_VAL) << 32;
    localparam logic [63:0] MSTATUS_INI = MSTATUS_RST | FIXED_BITS;
    localparam logic [XLEN-1:0] EPC_MASK = ~XLEN'(1);

    logic [63:0] wd64;
    assign wd64 = 64'(wdata);

    always_comb begin
        mstatus_nxt = mstatus_q;
        if (wr_mstatus) mstatus_nxt = (wd64 & MSTATUS_WMASK) | (mstatus_q & ~MSTATUS_WMASK);
        mepc_nxt = mepc_q;
        if (wr_mepc) mepc_nxt = wdata & EPC_MASK;
    end

    generate
        if (HAS_UMODE != 0) begin : g_menc
            always_comb begin
                menc_nxt = menc_q;
                if (wr_mcounteren) menc_nxt = 32'(wdata) & MCOUNTEREN_MASK;
            end
        end else begin : g_no_menc
            logic unused_wr;
            assign unused_wr = wr_mcounteren;
            assign menc_nxt  = '0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mstatus_q <= MSTATUS_INI;
            mepc_q    <= '0;
            menc_q    <= '0;
        end else begin
            mstatus_q <= mstatus_nxt;
            mepc_q    <= mepc_nxt;
            menc_q    <= menc_nxt;
        end
    end

    // R10: reserved status bits never hold a one
    p_mstatus_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mstatus_q & ~(MSTATUS_WMASK | FIXED_BITS)) == 64'd0);

    // R9: only the two implemented enable bits can be set
    p_menc_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (menc_q & ~MCOUNTEREN_MASK) == 32'd0);

    // R2: a write stores bit 1 of the return address
    p_mepc_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_mepc)) |-> (mepc_q[1] == $past(wdata[1])));

endmodule

// File: rtl/mcsr_trace_unit.sv
module mcsr_trace_unit
    import mcsr_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int HAS_UMODE = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            c_align_en,
    input  logic            acc_valid,
    input  logic            acc_we,
    input  logic [11:0]     acc_addr,
    input  logic [XLEN-1:0] acc_wdata,
    output logic [XLEN-1:0] acc_rdata,
    output logic            acc_illegal,
    input  logic            ret_valid,
    output logic            tr_valid,
    output logic [63:0]     tr_mstatus_rdata,
    output logic [63:0]     tr_mstatus_wdata,
    output logic [63:0]     tr_mepc_rdata,
    output logic [63:0]     tr_mepc_wdata,
    output logic [31:0]     tr_mcounteren_rdata,
    output logic [31:0]     tr_mcounteren_wdata,
    output logic [63:0]     tr_mcycle_rdata,
    output logic [63:0]     tr_mcycle_wdata,
    output logic [63:0]     tr_minstret_rdata,
    output logic [63:0]     tr_minstret_wdata
);

    localparam logic [1:0] UXL_VAL = (HAS_UMODE == 0) ? 2'b00 :
                                     ((XLEN == 64) ? 2'b10 : 2'b01);

    csr_sel_e        sel;
    logic            wr_en;
    logic            wr_cyc_lo, wr_cyc_hi, wr_ret_lo, wr_ret_hi;
    logic [63:0]     mstatus_q, mstatus_nxt;
    logic [XLEN-1:0] mepc_q, mepc_nxt, mepc_view;
    logic [31:0]     menc_q, menc_nxt;
    logic [63:0]     cyc_q, cyc_wr, ret_q, ret_wr;

    mcsr_decode #(.XLEN(XLEN), .HAS_UMODE(HAS_UMODE)) u_dec (
        .addr (acc_addr),
        .sel  (sel)
    );

    assign acc_illegal = acc_valid && (sel == SEL_NONE);
    assign wr_en       = acc_valid && acc_we && (sel != SEL_NONE);
    assign wr_cyc_lo   = wr_en && (sel == SEL_CYC_LO);
    assign wr_cyc_hi   = wr_en && (sel == SEL_CYC_HI);
    assign wr_ret_lo   = wr_en && (sel == SEL_RET_LO);
    assign wr_ret_hi   = wr_en && (sel == SEL_RET_HI);

    mcsr_regs #(.XLEN(XLEN), .HAS_UMODE(HAS_UMODE), .UXL_VAL(UXL_VAL)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_mstatus    (wr_en && (sel == SEL_MSTATUS)),
        .wr_mcounteren (wr_en && (sel == SEL_MCOUNTEREN)),
        .wr_mepc       (wr_en && (sel == SEL_MEPC)),
        .wdata         (acc_wdata),
        .mstatus_q     (mstatus_q),
        .mstatus_nxt   (mstatus_nxt),
        .mepc_q        (mepc_q),
        .mepc_nxt      (mepc_nxt),
        .menc_q        (menc_q),
        .menc_nxt      (menc_nxt)
    );

    mcsr_counter #(.XLEN(XLEN)) u_cycle (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (1'b1),
        .wr_lo  (wr_cyc_lo),
        .wr_hi  (wr_cyc_hi),
        .wdata  (acc_wdata),
        .cnt_q  (cyc_q),
        .cnt_wr (cyc_wr)
    );

    mcsr_counter #(.XLEN(XLEN)) u_instret (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (ret_valid),
        .wr_lo  (wr_ret_lo),
        .wr_hi  (wr_ret_hi),
        .wdata  (acc_wdata),
        .cnt_q  (ret_q),
        .cnt_wr (ret_wr)
    );

    // Software view: bit 1 hidden without 16-bit alignment.
    always_comb begin
        mepc_view    = mepc_q;
        mepc_view[1] = mepc_q[1] & c_align_en;
    end

    always_comb begin
        unique case (sel)
            SEL_MSTATUS:    acc_rdata = mstatus_q[XLEN-1:0];
            SEL_MCOUNTEREN: acc_rdata = XLEN'(menc_q);
            SEL_MEPC:       acc_rdata = mepc_view;
            SEL_CYC_LO:     acc_rdata = cyc_q[XLEN-1:0];
            SEL_CYC_HI:     acc_rdata = XLEN'(cyc_q[63:32]);
            SEL_RET_LO:     acc_rdata = ret_q[XLEN-1:0];
            SEL_RET_HI:     acc_rdata = XLEN'(ret_q[63:32]);
            default:        acc_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tr_valid            <= 1'b0;
            tr_mstatus_rdata    <= '0;
            tr_mstatus_wdata    <= '0;
            tr_mepc_rdata       <= '0;
            tr_mepc_wdata       <= '0;
            tr_mcounteren_rdata <= '0;
            tr_mcounteren_wdata <= '0;
            tr_mcycle_rdata     <= '0;
            tr_mcycle_wdata     <= '0;
            tr_minstret_rdata   <= '0;
            tr_minstret_wdata   <= '0;
        end else begin
            tr_valid <= ret_valid;
            if (ret_valid) begin
                tr_mstatus_rdata    <= mstatus_q;
                tr_mstatus_wdata    <= mstatus_nxt;
                tr_mepc_rdata       <= 64'(mepc_q);
                tr_mepc_wdata       <= 64'(mepc_nxt);
                tr_mcounteren_rdata <= menc_q;
                tr_mcounteren_wdata <= menc_nxt;
                tr_mcycle_rdata     <= cyc_q;
                tr_mcycle_wdata     <= cyc_wr;
                tr_minstret_rdata   <= ret_q;
                tr_minstret_wdata   <= ret_wr;
            end
        end
    end

    // R12: trace valid follows retirement by one cycle
    p_trace_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> tr_valid);

    // R7: counters unchanged across a retirement that does not write them
    p_trace_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !(wr_cyc_lo || wr_cyc_hi || wr_ret_lo || wr_ret_hi)) |=>
        ((tr_mcycle_rdata == tr_mcycle_wdata) && (tr_minstret_rdata == tr_minstret_wdata)));

    // R3: the trace carries stored bit 1, never the masked view
    p_mepc_trace_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> (tr_mepc_rdata == 64'($past(mepc_q))));

    // R11: an illegal access touches no register
    p_illegal_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_illegal) |=>
        ($stable(mstatus_q) && $stable(mepc_q) && $stable(menc_q)));

endmodule

// File: tb/mcsr_trace_unit_tb_top.sv
`timescale 1ns/1ps
module mcsr_trace_unit_tb_top;
    import mcsr_pkg::*;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            c_align_en = 1'b0;
    logic            acc_valid = 1'b0;
    logic            acc_we = 1'b0;
    logic [11:0]     acc_addr = '0;
    logic [XLEN-1:0] acc_wdata = '0;
    logic            ret_valid = 1'b0;
    logic [XLEN-1:0] acc_rdata;
    logic            acc_illegal;
    logic            tr_valid;
    logic [63:0]     tr_mstatus_rdata, tr_mstatus_wdata, tr_mepc_rdata, tr_mepc_wdata;
    logic [31:0]     tr_mcounteren_rdata, tr_mcounteren_wdata;
    logic [63:0]     tr_mcycle_rdata, tr_mcycle_wdata, tr_minstret_rdata, tr_minstret_wdata;

    always #2.5 clk = ~clk;

    mcsr_trace_unit #(.XLEN(XLEN), .HAS_UMODE(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .c_align_en(c_align_en),
        .acc_valid(acc_valid), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_illegal(acc_illegal),
        .ret_valid(ret_valid), .tr_valid(tr_valid),
        .tr_mstatus_rdata(tr_mstatus_rdata), .tr_mstatus_wdata(tr_mstatus_wdata),
        .tr_mepc_rdata(tr_mepc_rdata), .tr_mepc_wdata(tr_mepc_wdata),
        .tr_mcounteren_rdata(tr_mcounteren_rdata), .tr_mcounteren_wdata(tr_mcounteren_wdata),
        .tr_mcycle_rdata(tr_mcycle_rdata), .tr_mcycle_wdata(tr_mcycle_wdata),
        .tr_minstret_rdata(tr_minstret_rdata), .tr_minstret_wdata(tr_minstret_wdata)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] rd;
    logic        ill;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic v, input logic we, input logic [11:0] a,
                          input logic [31:0] d, input logic r);
        @(negedge clk);
        acc_valid = v; acc_we = we; acc_addr = a; acc_wdata = d; ret_valid = r;
        #1;
        rd  = acc_rdata;
        ill = acc_illegal;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_we = 1'b0; ret_valid = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        access(1'b1, 1'b0, a, 32'h0, 1'b0);
        check(req, 64'(rd), 64'(exp));
    endtask

    function automatic logic implemented(input logic [11:0] a);
        return a inside {A_MSTATUS, A_MCOUNTEREN, A_MEPC, A_MCYCLE, A_MINSTRET,
                         A_MCYCLEH, A_MINSTRETH};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] c0, m0, st;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 mstatus", A_MSTATUS, 32'h1800);
        rdchk("R1 mepc", A_MEPC, 32'h0);
        rdchk("R1 mcounteren", A_MCOUNTEREN, 32'h0);
        rdchk("R1 minstret", A_MINSTRET, 32'h0);
        rdchk("R1 minstreth", A_MINSTRETH, 32'h0);
        rdchk("R1 mcycleh", A_MCYCLEH, 32'h0);
        check("R12 no trace without retire", 64'(tr_valid), 64'd0);

        // R11 full address sweep, reads then writes to unimplemented addresses
        for (int a = 0; a < 4096; a++) begin
            access(1'b1, 1'b0, 12'(a), 32'h0, 1'b0);
            check("R11 illegal flag on read", 64'(ill), 64'(!implemented(12'(a))));
        end
        for (int a = 0; a < 4096; a++) begin
            if (!implemented(12'(a))) begin
                access(1'b1, 1'b1, 12'(a), 32'hFFFF_FFFF, 1'b0);
                check("R11 illegal flag on write", 64'(ill), 64'd1);
            end
        end
        rdchk("R11 mstatus untouched", A_MSTATUS, 32'h1800);
        rdchk("R11 mepc untouched", A_MEPC, 32'h0);
        rdchk("R11 mcounteren untouched", A_MCOUNTEREN, 32'h0);
        rdchk("R11 minstret untouched", A_MINSTRET, 32'h0);

        // R10 status word fields
        for (int k = 0; k < 32; k++) begin
            access(1'b1, 1'b1, A_MSTATUS, 32'h1 << k, 1'b0);
            rdchk("R10 mstatus single bit", A_MSTATUS, (32'h1 << k) & 32'h1888);
        end
        access(1'b1, 1'b1, A_MSTATUS, 32'hFFFF_FFFF, 1'b0);
        rdchk("R10 mstatus all ones", A_MSTATUS, 32'h1888);
        access(1'b1, 1'b0, A_MSTATUS, 32'h0, 1'b1);
        check("R12 trace valid", 64'(tr_valid), 64'd1);
        check("R10 trace mstatus rdata layout", tr_mstatus_rdata, 64'h0000_0001_0000_1888);
        check("R10 trace mstatus wdata layout", tr_mstatus_wdata, 64'h0000_0001_0000_1888);
        access(1'b1, 1'b1, A_MSTATUS, 32'h0, 1'b1);
        check("R12 trace mstatus before", tr_mstatus_rdata, 64'h0000_0001_0000_1888);
        check("R12 trace mstatus after", tr_mstatus_wdata, 64'h0000_0001_0000_0000);

        // R9 counter-enable mask
        for (int k = 0; k < 16; k++) begin
            access(1'b1, 1'b1, A_MCOUNTEREN, 32'(k) * 32'h1111_1111, 1'b0);
            rdchk("R9 mcounteren pattern", A_MCOUNTEREN, (32'(k) * 32'h1111_1111) & 32'h5);
        end
        access(1'b1, 1'b1, A_MCOUNTEREN, 32'h0, 1'b0);
        access(1'b1, 1'b1, A_MCOUNTEREN, 32'hFFFF_FFFF, 1'b1);
        check("R12 trace mcounteren before", 64'(tr_mcounteren_rdata), 64'h0);
        check("R9 trace mcounteren after", 64'(tr_mcounteren_wdata), 64'h5);

        // R2 / R3 return address low bits
        for (int v = 0; v < 16; v++) begin
            st = (32'hABCD_0000 | 32'(v)) & ~32'h1;
            access(1'b1, 1'b1, A_MEPC, 32'hABCD_0000 | 32'(v), 1'b0);
            for (int al = 0; al < 2; al++) begin
                c_align_en = al[0];
                access(1'b1, 1'b0, A_MEPC, 32'h0, 1'b1);
                check("R2 mepc read view", 64'(rd), al[0] ? 64'(st) : 64'(st & ~32'h2));
                check("R3 mepc trace unmasked", tr_mepc_rdata, 64'(st));
                check("R3 mepc trace after", tr_mepc_wdata, 64'(st));
            end
        end
        c_align_en = 1'b0;
        access(1'b1, 1'b1, A_MEPC, 32'h1234_5677, 1'b1);
        check("R3 mepc trace write stores bit 1", tr_mepc_wdata, 64'h1234_5676);
        rdchk("R2 mepc masked read", A_MEPC, 32'h1234_5674);

        // R5 cycle counting
        access(1'b1, 1'b0, A_MCYCLE, 32'h0, 1'b0);
        c0 = rd;
        repeat (7) @(posedge clk);
        #1;
        access(1'b1, 1'b0, A_MCYCLE, 32'h0, 1'b0);
        check("R5 mcycle advances each cycle", 64'(rd - c0), 64'd8);

        // R4 split halves and carry
        access(1'b1, 1'b1, A_MCYCLEH, 32'h5, 1'b0);
        access(1'b1, 1'b1, A_MCYCLE, 32'hFFFF_FFFE, 1'b0);
        rdchk("R8 mcycle write value held", A_MCYCLE, 32'hFFFF_FFFE);
        rdchk("R4 mcycleh before carry", A_MCYCLEH, 32'h5);
        access(1'b1, 1'b0, A_MSTATUS, 32'h0, 1'b1);
        check("R4 trace mcycle 64-bit carry", tr_mcycle_rdata, 64'h0000_0006_0000_0000);
        check("R7 trace mcycle equal", tr_mcycle_wdata, 64'h0000_0006_0000_0000);
        access(1'b1, 1'b1, A_MCYCLE, 32'h40, 1'b1);
        check("R8 trace mcycle before", tr_mcycle_rdata, 64'h0000_0006_0000_0001);
        check("R8 trace mcycle after write", tr_mcycle_wdata, 64'h0000_0006_0000_0040);
        rdchk("R8 mcycle no increment on write", A_MCYCLE, 32'h40);
        rdchk("R5 mcycle resumes", A_MCYCLE, 32'h41);

        // R6 / R7 / R8 retired counter
        access(1'b1, 1'b0, A_MINSTRET, 32'h0, 1'b0);
        m0 = rd;
        for (int i = 0; i < 3; i++) begin
            access(1'b1, 1'b0, A_MSTATUS, 32'h0, 1'b1);
            check("R7 trace minstret rdata", tr_minstret_rdata, 64'(m0 + 32'(i)));
            check("R7 trace minstret wdata", tr_minstret_wdata, 64'(m0 + 32'(i)));
        end
        rdchk("R6 minstret counts retirements", A_MINSTRET, m0 + 32'd3);
        idle_hold: begin
            repeat (4) @(posedge clk);
            #1;
        end
        rdchk("R6 minstret holds without retire", A_MINSTRET, m0 + 32'd3);
        access(1'b1, 1'b1, A_MINSTRET, 32'h100, 1'b1);
        check("R8 trace minstret before", tr_minstret_rdata, 64'(m0 + 32'd3));
        check("R8 trace minstret after", tr_minstret_wdata, 64'h100);
        rdchk("R8 minstret no increment on write", A_MINSTRET, 32'h100);
        access(1'b1, 1'b0, A_MEPC, 32'h0, 1'b1);
        check("R7 trace minstret steady", tr_minstret_wdata, 64'h100);
        rdchk("R6 minstret after retire", A_MINSTRET, 32'h101);
        access(1'b1, 1'b1, A_MINSTRETH, 32'h7, 1'b1);
        check("R4 trace minstret high write", tr_minstret_wdata, 64'h0000_0007_0000_0101);
        rdchk("R4 minstreth readback", A_MINSTRETH, 32'h7);
        rdchk("R8 minstret low kept", A_MINSTRET, 32'h101);
        @(negedge clk);
        check("R12 trace drops after retire", 64'(tr_valid), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule